// File: doc/BRIEF.md
# Processor exception entry controller

This block performs the state changes a 32-bit core with branch delay slots makes when it takes an exception. One of several requesters presents an exception kind, the faulting virtual address and a coprocessor number. The core supplies the current PC, the next PC and the present values of its Status, Cause, shadow-set control, exception base, TLB entry-high and TLB context registers. One clock later the block returns the new values of those registers and a one-cycle redirect carrying the handler address. The core writes these values back. A separate boot request sends the core to the power-on vector.

The handler address depends on the exception kind and on the exception-level, bootstrap and interrupt-vector bits as they were before entry. The saved return address is moved back one instruction when the faulting instruction sits in a delay slot. The shadow-set fields are rotated only when the core was running normally before entry.

Top module: `exc_entry`

## Requirements
- R1: The exception kind is 5 bits {refill, code[3:0]}. The code goes into Cause[6:2] as {0,code}. The codes are: interrupt 0x0, TLB modified 0x1, TLB load/fetch 0x2, TLB store 0x3, load address error 0x4, store address error 0x5, syscall 0x8, breakpoint 0x9, reserved instruction 0xA, coprocessor unusable 0xB, overflow 0xC, trap 0xD. All other Cause bits not named in R2 or R8 pass through unchanged.
- R2: When npc differs from pc+4, the saved return address epc_o is pc-4 and Cause[31] is set. Otherwise epc_o is pc and Cause[31] is cleared.
- R3: status_o equals status_i with bit 1 (exception level) forced to 1, whatever its prior value.
- R4: When Status bit 1 and Status bit 22 (bootstrap) were both 0 before entry, the shadow-set control is rotated: bits [9:6] take old bits [3:0], and bits [3:0] take bits [15:12]. Otherwise it passes through unchanged.
- R5: With refill=1 and code 0x2 or 0x3, the handler is at ebase when Status bit 1 was 0, and at ebase+0x180 when it was 1.
- R6: An interrupt with Cause bit 23 set vectors to ebase+0x200. Every other exception not covered by R5 or R7 vectors to ebase+0x180.
- R7: An overflow (0xC) taken while Status bit 22 is 1 vectors to 0xBFC00200.
- R8: Cause[29:28] receives the request's coprocessor number for code 0xB and is cleared for every other code.
- R9: For codes 0x1 to 0x5, badva_we is asserted and badva_o is the faulting address. For codes 0x1 to 0x3, tlb_we is asserted as well. entryhi_o[31:13] and context_o[22:4] then take address[31:13], and the remaining bits of both pass through. For all other codes both enables stay low.
- R10: A boot request redirects to 0xBFC00000 with cp0_we, badva_we and tlb_we all low.
- R11: A request accepted at one clock edge produces the outputs and a one-cycle redirect pulse after that edge. redir_npc and redir_nnpc are the handler address +4 and +8.
- R12: A boot request wins over exception requests. Among exception requests, the lowest-numbered valid input wins. Requests presented while redir is high are ignored.
- R13: While rst_n is low, redir and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_req | input | 1 | Request to enter the power-on vector |
| req_valid | input | NREQ | Per-requester exception request |
| req_kind | input | NREQ*5 | Per-requester {refill, code} |
| req_addr | input | NREQ*32 | Per-requester faulting address |
| req_cop | input | NREQ*2 | Per-requester coprocessor number |
| pc | input | 32 | PC of the faulting instruction |
| npc | input | 32 | Next PC |
| status_i | input | 32 | Current Status |
| cause_i | input | 32 | Current Cause |
| srsctl_i | input | 32 | Current shadow-set control |
| ebase_i | input | 32 | Exception base address |
| entryhi_i | input | 32 | Current TLB entry-high |
| context_i | input | 32 | Current TLB context |
| redir | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Handler address |
| redir_npc | output | 32 | Handler address + 4 |
| redir_nnpc | output | 32 | Handler address + 8 |
| cp0_we | output | 1 | Write EPC, Cause, Status, shadow-set control |
| epc_o | output | 32 | New return address |
| cause_o | output | 32 | New Cause |
| status_o | output | 32 | New Status |
| srsctl_o | output | 32 | New shadow-set control |
| badva_we | output | 1 | Write bad-address register |
| badva_o | output | 32 | New bad address |
| tlb_we | output | 1 | Write entry-high and context |
| entryhi_o | output | 32 | New entry-high |
| context_o | output | 32 | New context |

## Verification
The block holds almost no state, so an error appears at the ports in the cycle right after the request edge. Wrong arbitration shows up as the losing requester's code in Cause or its address in the bad-address register. A wrong exception-level, bootstrap or delay-slot decision shows up as a wrong handler address, a wrong saved return address or wrong shadow-set fields. A stuck redirect shows up on the following edge, as a second pulse or as a request that is accepted when it should have been ignored.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int          NREQ        = 2,
  parameter logic [31:0] BOOT_VEC    = 32'hBFC0_0000,
  parameter logic [31:0] OVF_BEV_VEC = 32'hBFC0_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_req,
  input  logic [NREQ-1:0]   req_valid,
  input  logic [NREQ*5-1:0] req_kind,
  input  logic [NREQ*32-1:0] req_addr,
  input  logic [NREQ*2-1:0] req_cop,
  input  logic [31:0]       pc,
  input  logic [31:0]       npc,
  input  logic [31:0]       status_i,
  input  logic [31:0]       cause_i,
  input  logic [31:0]       srsctl_i,
  input  logic [31:0]       ebase_i,
  input  logic [31:0]       entryhi_i,
  input  logic [31:0]       context_i,
  output logic              redir,
  output logic [31:0]       redir_pc,
  output logic [31:0]       redir_npc,
  output logic [31:0]       redir_nnpc,
  output logic              cp0_we,
  output logic [31:0]       epc_o,
  output logic [31:0]       cause_o,
  output logic [31:0]       status_o,
  output logic [31:0]       srsctl_o,
  output logic              badva_we,
  output logic [31:0]       badva_o,
  output logic              tlb_we,
  output logic [31:0]       entryhi_o,
  output logic [31:0]       context_o
);

  localparam logic [3:0] C_COPU = 4'hB;
  localparam logic [3:0] C_OVF  = 4'hC;

  logic        hit;
  logic [4:0]  kind;
  logic [31:0] addr;
  logic [1:0]  cop;

  always_comb begin
    hit  = 1'b0;
    kind = '0;
    addr = '0;
    cop  = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_valid[i]) begin
        hit  = 1'b1;
        kind = req_kind[i*5 +: 5];
        addr = req_addr[i*32 +: 32];
        cop  = req_cop[i*2 +: 2];
      end
    end
  end

  wire [3:0] code    = kind[3:0];
  wire       exl     = status_i[1];
  wire       bev     = status_i[22];
  wire       iv      = cause_i[23];
  wire       refill  = kind[4] && (code == 4'h2 || code == 4'h3);
  wire       is_tlb  = code >= 4'h1 && code <= 4'h3;
  wire       is_badv = code >= 4'h1 && code <= 4'h5;
  wire       dslot   = npc != pc + 32'd4;
  wire       take    = !redir && (boot_req || hit);
  wire       exc     = take && !boot_req;

  logic [31:0] vec;
  always_comb begin
    if (refill && !exl)            vec = ebase_i;
    else if (code == C_OVF && bev) vec = OVF_BEV_VEC;
    else if (code == 4'h0 && iv)   vec = ebase_i + 32'h200;
    else                           vec = ebase_i + 32'h180;
  end

  logic [31:0] srs_rot;
  always_comb begin
    srs_rot = srsctl_i;
    if (!exl && !bev) begin
      srs_rot[9:6] = srsctl_i[3:0];
      srs_rot[3:0] = srsctl_i[15:12];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir     <= 1'b0;
      cp0_we    <= 1'b0;
      badva_we  <= 1'b0;
      tlb_we    <= 1'b0;
      redir_pc  <= '0;
      epc_o     <= '0;
      cause_o   <= '0;
      status_o  <= '0;
      srsctl_o  <= '0;
      badva_o   <= '0;
      entryhi_o <= '0;
      context_o <= '0;
    end else begin
      redir    <= take;
      cp0_we   <= exc;
      badva_we <= exc && is_badv;
      tlb_we   <= exc && is_tlb;
      if (take) begin
        redir_pc  <= boot_req ? BOOT_VEC : vec;
        epc_o     <= dslot ? pc - 32'd4 : pc;
        cause_o   <= {dslot, cause_i[30], (code == C_COPU) ? cop : 2'b00,
                      cause_i[27:7], 1'b0, code, cause_i[1:0]};
        status_o  <= status_i | 32'h2;
        srsctl_o  <= srs_rot;
        badva_o   <= addr;
        entryhi_o <= {addr[31:13], entryhi_i[12:0]};
        context_o <= {context_i[31:23], addr[31:13], context_i[3:0]};
      end
    end
  end

  assign redir_npc  = redir_pc + 32'd4;
  assign redir_nnpc = redir_pc + 32'd8;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic        redir,
  input logic        cp0_we,
  input logic        badva_we,
  input logic        tlb_we,
  input logic [31:0] redir_pc,
  input logic [31:0] epc_o,
  input logic [31:0] cause_o,
  input logic [31:0] status_o,
  input logic [31:0] badva_o,
  input logic [31:0] entryhi_o
);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> !redir);

  a_r3_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    cp0_we |-> status_o[1]);

  a_r10_boot_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (redir && !cp0_we) |-> (redir_pc == 32'hBFC0_0000 && !badva_we && !tlb_we));

  a_r8_ce_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cp0_we && cause_o[6:2] != 5'h0B) |-> cause_o[29:28] == 2'b00);

  a_r2_epc_bd: assert property (@(posedge clk) disable iff (!rst_n)
    cp0_we |-> (cause_o[31] ? (epc_o == $past(pc) - 32'd4) : (epc_o == $past(pc))));

  a_r9_tlb_fields: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we |-> (badva_we && badva_o[31:13] == entryhi_o[31:13]));

  a_r13_we_with_redir: assert property (@(posedge clk) disable iff (!rst_n)
    (cp0_we || badva_we || tlb_we) |-> redir);

endmodule

bind exc_entry exc_entry_chk u_chk (.*);

// File: tb/exc_entry_tb.sv
`timescale 1ns/1ps
module exc_entry_tb;
  localparam int NREQ = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, boot_req;
  logic [NREQ-1:0] req_valid;
  logic [NREQ*5-1:0] req_kind;
  logic [NREQ*32-1:0] req_addr;
  logic [NREQ*2-1:0] req_cop;
  logic [31:0] pc, npc, status_i, cause_i, srsctl_i, ebase_i, entryhi_i, context_i;
  logic redir, cp0_we, badva_we, tlb_we;
  logic [31:0] redir_pc, redir_npc, redir_nnpc, epc_o, cause_o, status_o, srsctl_o;
  logic [31:0] badva_o, entryhi_o, context_o;

  exc_entry #(.NREQ(NREQ)) u_dut (.*);

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec(input logic [3:0] c, input logic rf,
      input logic x, input logic b, input logic v, input logic [31:0] eb);
    if (rf && (c == 4'h2 || c == 4'h3) && !x) return eb;
    if (c == 4'hC && b) return 32'hBFC0_0200;
    if (c == 4'h0 && v) return eb + 32'h200;
    return eb + 32'h180;
  endfunction

  task automatic idle;
    boot_req = 0; req_valid = '0;
  endtask

  initial begin
    logic [3:0] codes [12];
    logic [31:0] a, ec, es, ep;
    logic [3:0] c;
    codes = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD};
    rst_n = 0; idle(); req_kind = '0; req_addr = '0; req_cop = '0;
    pc = 32'h8000_1000; npc = 32'h8000_1004;
    status_i = 0; cause_i = 0; srsctl_i = 32'h0000_A0C5; ebase_i = 32'h8000_0000;
    entryhi_i = 32'h0000_105A; context_i = 32'hFF80_000F;
    req_valid = 2'b11; boot_req = 1;
    repeat (3) @(negedge clk);
    chk("R13 redir in reset", {31'b0, redir}, 0);
    chk("R13 we in reset", {29'b0, cp0_we, badva_we, tlb_we}, 0);
    idle();
    rst_n = 1;
    @(negedge clk);

    for (int ci = 0; ci < 12; ci++)
      for (int rf = 0; rf < 2; rf++)
        for (int m = 0; m < 16; m++) begin
          c = codes[ci];
          if (rf == 1 && c != 4'h2 && c != 4'h3) continue;
          a = 32'hC0DE_0000 ^ (32'(ci) << 13) ^ 32'(m);
          status_i = 32'h1000_0000 | (32'(m[0]) << 1) | (32'(m[1]) << 22);
          cause_i  = 32'hB000_037C | (32'(m[2]) << 23);
          npc = m[3] ? 32'h8000_2000 : pc + 4;
          req_kind[4:0] = {rf[0], c};
          req_addr[31:0] = a;
          req_cop[1:0] = 2'(ci);
          req_valid = 2'b01;
          @(negedge clk);
          chk("R11 redir", {31'b0, redir}, 1);
          chk("R5 R6 R7 vector", redir_pc, exp_vec(c, rf[0], m[0], m[1], m[2], ebase_i));
          chk("R11 npc", redir_npc, exp_vec(c, rf[0], m[0], m[1], m[2], ebase_i) + 4);
          chk("R11 nnpc", redir_nnpc, exp_vec(c, rf[0], m[0], m[1], m[2], ebase_i) + 8);
          chk("R2 epc", epc_o, m[3] ? pc - 4 : pc);
          ec = cause_i; ec[31] = m[3]; ec[29:28] = (c == 4'hB) ? 2'(ci) : 2'b00;
          ec[6:2] = {1'b0, c};
          chk("R1 R2 R8 cause", cause_o, ec);
          chk("R3 status", status_o, status_i | 32'h2);
          es = (!m[0] && !m[1]) ? 32'h0000_A14A : 32'h0000_A0C5;
          chk("R4 srsctl", srsctl_o, es);
          chk("R9 enables", {29'b0, cp0_we, badva_we, tlb_we},
              {29'b0, 1'b1, (c >= 1 && c <= 5), (c >= 1 && c <= 3)});
          if (c >= 1 && c <= 5) chk("R9 badva", badva_o, a);
          if (c >= 1 && c <= 3) begin
            chk("R9 entryhi", entryhi_o, {a[31:13], 13'h105A});
            ep = {9'h1FF, a[31:13], 4'hF};
            chk("R9 context", context_o, ep);
          end
          idle();
          @(negedge clk);
          chk("R11 pulse ends", {31'b0, redir}, 0);
        end

    // R12 priority among requesters
    npc = pc + 4; status_i = 0; cause_i = 0;
    req_kind = {5'h08, 5'h0D}; req_addr = {32'h1111_1111, 32'h2222_2222}; req_cop = '0;
    req_valid = 2'b11;
    @(negedge clk);
    chk("R12 lowest wins", {27'b0, cause_o[6:2]}, 32'h0D);
    // request held while redir high must be ignored
    req_kind = {5'h08, 5'h08};
    @(negedge clk);
    chk("R12 ignored during redirect", {31'b0, redir}, 0);
    chk("R12 state unchanged", {27'b0, cause_o[6:2]}, 32'h0D);
    idle();
    @(negedge clk);
    // R12 boot beats exceptions, R10 boot vector
    req_valid = 2'b11; boot_req = 1;
    @(negedge clk);
    chk("R10 boot pc", redir_pc, 32'hBFC0_0000);
    chk("R10 boot npc", redir_npc, 32'hBFC0_0004);
    chk("R10 boot nnpc", redir_nnpc, 32'hBFC0_0008);
    chk("R10 R12 boot no writes", {29'b0, cp0_we, badva_we, tlb_we}, 0);
    idle();
    @(negedge clk);
    // R12 second requester alone
    req_valid = 2'b10;
    @(negedge clk);
    chk("R12 upper requester", {27'b0, cause_o[6:2]}, 32'h08);
    chk("R9 syscall no badva", {31'b0, badva_we}, 0);
    idle();
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule